// File: doc/BRIEF.md
# I2C Serial Clock Duty-Cycle Generator

This block produces the serial clock of an I2C master from the system clock. The clock has two phases, each with its own programmable length. Software sets the number of system clock cycles for which the block pulls the line low, and, separately, the number of cycles for which the line stays released. The two lengths may differ, so the duty cycle can be asymmetric. One bit period is the sum of the two lengths. For example, a sum of 100 at a 40 MHz system clock gives a 400 kHz bit rate. A sum of 8 at 1 MHz gives 125 kHz, and a sum of 800 at 60 MHz gives 75 kHz.

The block only drives an open-drain pull-down request. It reads the real line level back through a two-flop synchroniser. Another device may hold the line low after the block has released it. The released-phase count then waits until the line is really high, so the other device stretches the clock by exactly the time it holds the line. Two single-cycle strobes mark the cycle in which the pull-down is released and the cycle in which it is applied. A byte-level controller uses them to shift data.

Any programmed length below 4 is treated as 4. Both lengths are captured only when a low phase begins, so a phase already running is never shortened or lengthened by a register write. While disabled, the block releases the line and clears its count.

Top module: `scl_pacer`

## Requirements
- R1: During reset and while `enable` is 0, `scl_drive_low`, `scl_rise_stb` and `scl_fall_stb` are all 0.
- R2: In the first cycle after `enable` is sampled 1 while idle, `scl_drive_low` is 1 and `scl_fall_stb` is 1. The bit sequence therefore always begins with a complete low phase.
- R3: Each low phase keeps `scl_drive_low` at 1 for exactly the captured low length, in system clock cycles.
- R4: When no other device holds the line, each released phase keeps `scl_drive_low` at 0 for exactly the captured high length. One bit period is therefore low length plus high length.
- R5: A programmed low or high value below 4 (including 0) is used as 4.
- R6: If another device holds `scl_in` low for H cycles starting in the first released cycle, the released phase lasts the high length plus H. Holding longer than the high length is allowed.
- R7: `low_period` and `high_period` are sampled only in the cycle a low phase starts. A write during a low or a high phase affects the following bit period, not the current one.
- R8: `scl_rise_stb` is 1 exactly in the first cycle of each released phase. `scl_fall_stb` is 1 exactly in the first cycle of each low phase. Each strobe lasts one cycle, and the two are never 1 together.
- R9: Clearing `enable` releases the line in the next cycle, from any phase, without producing either strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Runs the clock generator when 1 |
| low_period | input | CNT_W (16) | Low phase length in clock cycles (minimum 4) |
| high_period | input | CNT_W (16) | Released phase length in clock cycles (minimum 4) |
| scl_in | input | 1 | Sampled level of the shared clock line |
| scl_drive_low | output | 1 | Pull-down request for the open-drain line driver |
| scl_rise_stb | output | 1 | One-cycle strobe in the first released cycle |
| scl_fall_stb | output | 1 | One-cycle strobe in the first pulled-down cycle |

## Verification
A table of length pairs exercises the main function. The pairs are equal and unequal, short and long low/high ratios, and values below the minimum. They separate a correct per-phase count from one that swaps the two registers, is off by one, or skips the clamp. The bench also models the line with another device holding it low for 1, 5 and 20 cycles. These three cases separate exact stretch accounting from accounting that loses or doubles the synchroniser delay. Register writes placed mid-phase check that capture happens only at the start of a low phase. Enable is cleared in both phases, which shows that disabling neither emits a strobe nor leaves the line pulled down.

// File: rtl/scl_pacer_pkg.sv
`timescale 1ns/1ps
package scl_pacer_pkg;

   // Operating phase of the clock generator
   typedef enum logic [1:0] {
      PH_OFF  = 2'd0,   // disabled, line released
      PH_LOW  = 2'd1,   // pulling the line low
      PH_HIGH = 2'd2    // line released, counting high time
   } phase_e;

endpackage

// File: rtl/scl_pacer_sync.sv
`timescale 1ns/1ps
module scl_pacer_sync #(
   parameter int   STAGES  = 2,
   parameter logic RST_VAL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("scl_pacer_sync needs at least two stages");
      end
   endgenerate

   logic [STAGES-1:0] stg_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg_q <= {STAGES{RST_VAL}};
      else        stg_q <= {stg_q[STAGES-2:0], d};
   end

   assign q = stg_q[STAGES-1];

endmodule

// File: rtl/scl_pacer_limit.sv
`timescale 1ns/1ps
module scl_pacer_limit #(
   parameter int CNT_W     = 16,
   parameter int MIN_COUNT = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] raw_low,
   input  logic [CNT_W-1:0] raw_high,
   output logic [CNT_W-1:0] eff_low,
   output logic [CNT_W-1:0] eff_high
);

   localparam int                NCH   = 2;
   localparam logic [CNT_W-1:0]  FLOOR = CNT_W'(MIN_COUNT);

   logic [NCH-1:0][CNT_W-1:0] raw_v;
   logic [NCH-1:0][CNT_W-1:0] held_q;

   assign raw_v[0] = raw_low;
   assign raw_v[1] = raw_high;

   // One clamp-and-capture register per phase length
   generate
      for (genvar ch = 0; ch < NCH; ch++) begin : g_chan
         logic [CNT_W-1:0] clamped;
         assign clamped = (raw_v[ch] < FLOOR) ? FLOOR : raw_v[ch];

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)    held_q[ch] <= FLOOR;
            else if (load) held_q[ch] <= clamped;
         end
      end
   endgenerate

   assign eff_low  = held_q[0];
   assign eff_high = held_q[1];

endmodule

// File: rtl/scl_pacer_phase.sv
`timescale 1ns/1ps
module scl_pacer_phase
   import scl_pacer_pkg::*;
#(
   parameter int CNT_W       = 16,
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             enable,
   input  logic [CNT_W-1:0] low_len,
   input  logic [CNT_W-1:0] high_len,
   input  logic             line_high,
   output logic             load,
   output logic             drive_low,
   output logic             rise_stb,
   output logic             fall_stb
);

   // Cycles after release during which the synchronised line still
   // shows the old level; counting runs blind here to hide that latency.
   localparam logic [CNT_W-1:0] BLIND = CNT_W'(SYNC_STAGES);
   localparam logic [CNT_W-1:0] ONE   = CNT_W'(1);

   phase_e           phase_q;
   logic [CNT_W-1:0] cnt_q;
   logic             advance;
   logic             high_done;
   logic             low_done;
   logic             start_low;

   assign advance   = line_high || (cnt_q < BLIND);
   assign high_done = (phase_q == PH_HIGH) && advance && (cnt_q == high_len - ONE);
   assign low_done  = (phase_q == PH_LOW) && (cnt_q == low_len);
   assign start_low = enable && ((phase_q == PH_OFF) || high_done);
   assign load      = start_low;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q   <= PH_OFF;
         cnt_q     <= '0;
         drive_low <= 1'b0;
         rise_stb  <= 1'b0;
         fall_stb  <= 1'b0;
      end else begin
         rise_stb <= 1'b0;
         fall_stb <= 1'b0;
         if (!enable) begin
            phase_q   <= PH_OFF;
            cnt_q     <= '0;
            drive_low <= 1'b0;
         end else if (start_low) begin
            phase_q   <= PH_LOW;
            cnt_q     <= ONE;
            drive_low <= 1'b1;
            fall_stb  <= 1'b1;
         end else if (low_done) begin
            phase_q   <= PH_HIGH;
            cnt_q     <= '0;
            drive_low <= 1'b0;
            rise_stb  <= 1'b1;
         end else begin
            case (phase_q)
               PH_LOW:  cnt_q <= cnt_q + ONE;
               PH_HIGH: if (advance) cnt_q <= cnt_q + ONE;
               default: begin
                  phase_q   <= PH_OFF;
                  cnt_q     <= '0;
                  drive_low <= 1'b0;
               end
            endcase
         end
      end
   end

endmodule

// File: rtl/scl_pacer.sv
`timescale 1ns/1ps
module scl_pacer #(
   parameter int CNT_W       = 16,
   parameter int MIN_COUNT   = 4,
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             enable,
   input  logic [CNT_W-1:0] low_period,
   input  logic [CNT_W-1:0] high_period,
   input  logic             scl_in,
   output logic             scl_drive_low,
   output logic             scl_rise_stb,
   output logic             scl_fall_stb
);

   // Elaboration-time parameter checks
   generate
      if (SYNC_STAGES < 2) begin : g_chk_sync
         $error("SYNC_STAGES must be at least 2");
      end
      if (MIN_COUNT <= SYNC_STAGES) begin : g_chk_min
         $error("MIN_COUNT must exceed SYNC_STAGES");
      end
      if (CNT_W < 4 || CNT_W > 31) begin : g_chk_width
         $error("CNT_W out of supported range");
      end
   endgenerate

   logic             line_high;
   logic             load;
   logic [CNT_W-1:0] eff_low;
   logic [CNT_W-1:0] eff_high;

   scl_pacer_sync #(
      .STAGES  (SYNC_STAGES),
      .RST_VAL (1'b1)
   ) i_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (scl_in),
      .q     (line_high)
   );

   scl_pacer_limit #(
      .CNT_W     (CNT_W),
      .MIN_COUNT (MIN_COUNT)
   ) i_limit (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (load),
      .raw_low  (low_period),
      .raw_high (high_period),
      .eff_low  (eff_low),
      .eff_high (eff_high)
   );

   scl_pacer_phase #(
      .CNT_W       (CNT_W),
      .SYNC_STAGES (SYNC_STAGES)
   ) i_phase (
      .clk       (clk),
      .rst_n     (rst_n),
      .enable    (enable),
      .low_len   (eff_low),
      .high_len  (eff_high),
      .line_high (line_high),
      .load      (load),
      .drive_low (scl_drive_low),
      .rise_stb  (scl_rise_stb),
      .fall_stb  (scl_fall_stb)
   );

endmodule

// File: rtl/scl_pacer_chk.sv
`timescale 1ns/1ps
module scl_pacer_chk #(
   parameter int CNT_W     = 16,
   parameter int MIN_COUNT = 4
) (
   input logic clk,
   input logic rst_n,
   input logic enable,
   input logic scl_drive_low,
   input logic scl_rise_stb,
   input logic scl_fall_stb
);

   localparam logic [CNT_W:0] MIN_RUN = (CNT_W+1)'(MIN_COUNT);

   // Length of the current run of constant drive level, saturating
   logic [CNT_W:0] run_q;
   logic           last_q;
   logic           high_seen_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_q       <= '0;
         last_q      <= 1'b0;
         high_seen_q <= 1'b0;
      end else begin
         last_q <= scl_drive_low;
         if (scl_drive_low != last_q) run_q <= (CNT_W+1)'(1);
         else if (run_q != '1)        run_q <= run_q + 1'b1;
         if (!enable || scl_fall_stb) high_seen_q <= 1'b0;
         else if (scl_rise_stb)       high_seen_q <= 1'b1;
      end
   end

   p_off_released_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !enable |=> !scl_drive_low && !scl_rise_stb && !scl_fall_stb);

   p_start_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(enable) |=> scl_drive_low && scl_fall_stb);

   p_low_min_r5: assert property (@(posedge clk) disable iff (!rst_n)
      scl_rise_stb |-> run_q >= MIN_RUN);

   p_high_min_r4: assert property (@(posedge clk) disable iff (!rst_n)
      scl_fall_stb && high_seen_q |-> run_q >= MIN_RUN);

   p_strobe_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !(scl_rise_stb && scl_fall_stb));

   p_rise_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
      scl_rise_stb |=> !scl_rise_stb);

   p_fall_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
      scl_fall_stb |=> !scl_fall_stb);

   p_rise_at_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
      scl_rise_stb |-> !scl_drive_low && $past(scl_drive_low));

   p_fall_at_pull_r8: assert property (@(posedge clk) disable iff (!rst_n)
      scl_fall_stb |-> scl_drive_low && !$past(scl_drive_low));

   p_release_strobed_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(scl_drive_low) && $past(enable) |-> scl_rise_stb);

endmodule

bind scl_pacer scl_pacer_chk #(
   .CNT_W     (CNT_W),
   .MIN_COUNT (MIN_COUNT)
) i_scl_pacer_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .enable        (enable),
   .scl_drive_low (scl_drive_low),
   .scl_rise_stb  (scl_rise_stb),
   .scl_fall_stb  (scl_fall_stb)
);

// File: tb/test_scl_pacer.sv
`timescale 1ns/1ps
module test_scl_pacer;

   localparam int W  = 16;
   localparam int NV = 8;
   // programmed low, programmed high, expected low, expected high
   localparam int TV [NV][4] = '{
      '{  4,  4,   4,  4},
      '{ 10,  6,  10,  6},
      '{  0,  0,   4,  4},
      '{  3,  9,   4,  9},
      '{ 25, 75,  25, 75},
      '{  1,  2,   4,  4},
      '{100,  7, 100,  7},
      '{  5,  3,   5,  4}
   };

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         enable = 1'b0;
   logic [W-1:0] lo_reg = 16'd4;
   logic [W-1:0] hi_reg = 16'd4;
   logic         ext_hold = 1'b0;
   logic         scl_line;
   logic         drv_low;
   logic         rise_stb;
   logic         fall_stb;

   int checks = 0;
   int errors = 0;
   int both_bad = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   assign scl_line = !(drv_low || ext_hold);

   scl_pacer i_scl_pacer (
      .clk           (clk),
      .rst_n         (rst_n),
      .enable        (enable),
      .low_period    (lo_reg),
      .high_period   (hi_reg),
      .scl_in        (scl_line),
      .scl_drive_low (drv_low),
      .scl_rise_stb  (rise_stb),
      .scl_fall_stb  (fall_stb)
   );

   always @(negedge clk) if (rise_stb && fall_stb) both_bad++;

   task automatic check_eq(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual %0d expected %0d", tag, act, exp);
      end
   endtask

   // Starts at the negedge of the first low cycle, ends at the first released one
   task automatic run_low(output int n, input int poke_at, input int nlo, input int nhi);
      n = 1;
      while (1) begin
         if (poke_at != 0 && n == poke_at) begin
            lo_reg = W'(nlo);
            hi_reg = W'(nhi);
         end
         @(negedge clk);
         if (!drv_low) break;
         n++;
      end
      check_eq("R8 rise strobe in first released cycle", int'(rise_stb), 1);
   endtask

   // Starts at the negedge of the first released cycle, ends at the next low one
   task automatic run_high(output int n, input int poke_at, input int nlo, input int nhi,
                           input int hold);
      n = 1;
      while (1) begin
         if (hold > 0 && n == 1)        ext_hold = 1'b1;
         if (hold > 0 && n == hold + 1) ext_hold = 1'b0;
         if (poke_at != 0 && n == poke_at) begin
            lo_reg = W'(nlo);
            hi_reg = W'(nhi);
         end
         @(negedge clk);
         if (drv_low) break;
         n++;
      end
      ext_hold = 1'b0;
      check_eq("R8 fall strobe in first low cycle", int'(fall_stb), 1);
   endtask

   task automatic start_run(input int lo, input int hi);
      enable = 1'b0;
      lo_reg = W'(lo);
      hi_reg = W'(hi);
      repeat (2) @(negedge clk);
      enable = 1'b1;
      @(negedge clk);
      check_eq("R2 low phase and fall strobe after enable", int'(drv_low && fall_stb), 1);
   endtask

   initial begin
      int l1, h1, l2, h2, bad;
      // R1: reset state
      repeat (3) @(negedge clk);
      check_eq("R1 drive low in reset", int'(drv_low), 0);
      check_eq("R1 strobes in reset", int'(rise_stb || fall_stb), 0);
      rst_n = 1'b1;
      bad = 0;
      for (int i = 0; i < 20; i++) begin
         @(negedge clk);
         if (drv_low || rise_stb || fall_stb) bad++;
      end
      check_eq("R1 idle while disabled", bad, 0);

      // R3 R4 R5: table of phase lengths
      for (int v = 0; v < NV; v++) begin
         start_run(TV[v][0], TV[v][1]);
         run_low(l1, 0, 0, 0);
         run_high(h1, 0, 0, 0, 0);
         run_low(l2, 0, 0, 0);
         run_high(h2, 0, 0, 0, 0);
         check_eq("R3 R5 low phase length", l1, TV[v][2]);
         check_eq("R4 R5 high phase length", h1, TV[v][3]);
         check_eq("R4 bit period", l2 + h2, TV[v][2] + TV[v][3]);
      end

      // R7: writes take effect only at the next low start
      start_run(10, 10);
      run_low(l1, 3, 5, 20);
      check_eq("R7 low unchanged by mid-low write", l1, 10);
      run_high(h1, 3, 6, 8, 0);
      check_eq("R7 high unchanged by earlier writes", h1, 10);
      run_low(l1, 0, 0, 0);
      check_eq("R7 new low after capture", l1, 6);
      run_high(h1, 0, 0, 0, 0);
      check_eq("R7 new high after capture", h1, 8);

      // R6: stretching by another device (low 6, high 8)
      run_low(l1, 0, 0, 0);
      run_high(h1, 0, 0, 0, 5);
      check_eq("R6 stretch by 5", h1, 13);
      run_low(l1, 0, 0, 0);
      run_high(h1, 0, 0, 0, 1);
      check_eq("R6 stretch by 1", h1, 9);
      run_low(l1, 0, 0, 0);
      run_high(h1, 0, 0, 0, 20);
      check_eq("R6 stretch beyond high length", h1, 28);

      // R9: disable during a low phase
      repeat (2) @(negedge clk);
      enable = 1'b0;
      @(negedge clk);
      check_eq("R9 released after disable in low", int'(drv_low), 0);
      check_eq("R9 no rise strobe on disable", int'(rise_stb), 0);
      bad = 0;
      for (int i = 0; i < 10; i++) begin
         @(negedge clk);
         if (drv_low || rise_stb || fall_stb) bad++;
      end
      check_eq("R1 stays idle after disable", bad, 0);

      // R2: restart gives a full low phase
      enable = 1'b1;
      @(negedge clk);
      check_eq("R2 restart begins low", int'(drv_low && fall_stb), 1);
      run_low(l1, 0, 0, 0);
      check_eq("R2 restart low is complete", l1, 6);

      // R9: disable during a released phase
      enable = 1'b0;
      @(negedge clk);
      check_eq("R9 no fall strobe on disable in high", int'(fall_stb || drv_low), 0);

      check_eq("R8 strobes never together", both_bad, 0);

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog expired actual 0 expected 1");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule